// File: doc/BRIEF.md
# Memory-Mapped Tick and Timestamp Timer

This peripheral gives a processor a time base and periodic or single interrupts. It holds a free-running 32-bit timestamp counter and two down-counting event timers. It also has a status word of sticky pending flags. Software reaches every register through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and a combinational read-data return. Each event timer drives its own level interrupt line, which stays high while that timer's pending flag is set.

Each timer has one reload register. The register holds the count value and, in its two lowest bits, the enable and one-shot controls. A reload period is therefore always a multiple of four. Software can rewrite the period and keep the controls, because a read returns the controls in the low bits. A periodic timer reloads itself after each expiry. A one-shot timer clears its own enable bit and stops. The watchdog address window exists only as a hole in the map: it reads zero and ignores writes. All counting runs on the core clock.

Top module: `os_tick_timer`

## Requirements
- R1: After reset, every timer count, reload register and status bit reads zero, both interrupt lines are low, and the timestamp counts up from zero.
- R2: The timestamp at byte address 0x00 increases by one every clock. A write loads the written value, and counting continues from that value one clock later.
- R3: When the timestamp steps from 0xFFFFFFFF to zero, status bit 2 becomes set in the same clock edge. A write to the timestamp does not count as a wrap.
- R4: The reload registers sit at 0x08 (timer 0) and 0x10 (timer 1). Bit 0 is the enable, bit 1 selects one-shot, and bits 31:2 are the period. A read returns the word last stored. A write with bit 0 set loads the count with that word, bits 1:0 forced to zero, at the clock after the write.
- R5: The counts are read at 0x04 (timer 0) and 0x0C (timer 1). An enabled count that is not zero decrements by one per clock. A disabled count holds its value.
- R6: In periodic mode (bit 1 clear), an enabled timer whose count is zero sets its pending bit at the next clock and reloads with the period. Timer 0 uses status bit 0 and timer 1 uses status bit 1. Expiries therefore repeat every period+1 clocks.
- R7: In one-shot mode, at expiry the timer sets its pending bit, clears enable bit 0 of its reload register and leaves its count at zero. A reload write in the same clock takes precedence over that clear.
- R8: The status word at 0x20 is write-one-to-clear. Bits written as zero keep their value. A new event wins over a clear in the same clock. Bits 4:3 always read zero.
- R9: Each interrupt line irq_tmr[i] follows status bit i, cycle for cycle.
- R10: The count registers are read-only. The watchdog window 0x14 to 0x1C and every other unmapped address reads zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all counting advances on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| irq_tmr | output | NUM_TMR (2) | Per-timer interrupt, high while its pending bit is set |

## Verification
Read data is combinational, so the bench samples it in the same cycle it sets the address, one nanosecond after the falling edge. Register writes, timestamp steps and count decrements appear after the next rising edge. A count load needs two rising edges after a reload write. A pending bit, and so its interrupt line, rises at the edge after the count reads zero. The bench keeps a cycle model that it advances once per rising edge with the stimulus that edge sampled. Every read and every interrupt line is compared with that model in the low phase of the following cycle, so each result is checked in the cycle in which it is due.

// File: rtl/ostt_pkg.sv
package ostt_pkg;
   localparam int WORD_W      = 32;
   localparam int CTRL_W      = 2;
   localparam int EN_BIT      = 0;
   localparam int ONESHOT_BIT = 1;
   localparam int ST_STAMP    = 2;
   localparam int ST_SRC      = ST_STAMP + 1;
   localparam int ST_W        = 5;

   localparam int A_STAMP  = 'h00;
   localparam int A_STATUS = 'h20;
   localparam int A_STRIDE = 8;

   function automatic int tmr_cnt_addr(input int idx);
      return 4 + A_STRIDE * idx;
   endfunction

   function automatic int tmr_rld_addr(input int idx);
      return 8 + A_STRIDE * idx;
   endfunction
endpackage

// File: rtl/ostt_stamp.sv
module ostt_stamp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] stamp,
   output logic         wrap
);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= ld_val;
      else         q <= q + 1'b1;
   end

   assign stamp = q;
   assign wrap  = !ld && (q == {W{1'b1}});
endmodule

// File: rtl/ostt_downcount.sv
module ostt_downcount
   import ostt_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rld_we,
   input  logic [W-1:0] rld_wdata,
   output logic [W-1:0] rld,
   output logic [W-1:0] cnt,
   output logic         load_pend,
   output logic         expire
);
   logic [W-1:0] rld_q, cnt_q, base;
   logic         load_q, en, oneshot;

   assign en      = rld_q[EN_BIT];
   assign oneshot = rld_q[ONESHOT_BIT];
   assign base    = {rld_q[W-1:CTRL_W], {CTRL_W{1'b0}}};
   assign expire  = !load_q && en && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_q) begin
         cnt_q <= base;
      end else if (en) begin
         if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         else if (!oneshot) cnt_q <= base;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rld_q  <= '0;
         load_q <= 1'b0;
      end else begin
         load_q <= rld_we && rld_wdata[EN_BIT];
         if (rld_we)                 rld_q <= rld_wdata;
         else if (expire && oneshot) rld_q[EN_BIT] <= 1'b0;
      end
   end

   assign rld       = rld_q;
   assign cnt       = cnt_q;
   assign load_pend = load_q;
endmodule

// File: rtl/ostt_status.sv
module ostt_status #(
   parameter int N_SRC = 3,
   parameter int MW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set,
   input  logic             clr_we,
   input  logic [MW-1:0]    clr_mask,
   output logic [N_SRC-1:0] pend
);
   logic [N_SRC-1:0] q, clr_vec;

   assign clr_vec = clr_we ? clr_mask[N_SRC-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_vec) | set;
   end

   assign pend = q;
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
   import ostt_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_TMR = 2,
   parameter int CNT_W   = WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [NUM_TMR-1:0] irq_tmr
);
   generate
      if (NUM_TMR < 1 || NUM_TMR > ST_STAMP)
         $error("os_tick_timer: NUM_TMR must be 1 or 2");
      if (ADDR_W < 6)
         $error("os_tick_timer: ADDR_W too small for the register map");
      if (CNT_W <= ST_W)
         $error("os_tick_timer: CNT_W too narrow");
   endgenerate

   logic [CNT_W-1:0]              stamp_q;
   logic                          stamp_we, stamp_wrap;
   logic [NUM_TMR-1:0][CNT_W-1:0] rld, cnt;
   logic [NUM_TMR-1:0]            rld_we, load_pend, expire;
   logic [ST_SRC-1:0]             set_vec, pend;
   logic                          st_we;

   assign stamp_we = bus_we && (bus_addr == ADDR_W'(A_STAMP));
   assign st_we    = bus_we && (bus_addr == ADDR_W'(A_STATUS));

   ostt_stamp #(.W(CNT_W)) u_stamp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (stamp_we),
      .ld_val (bus_wdata),
      .stamp  (stamp_q),
      .wrap   (stamp_wrap)
   );

   for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
      assign rld_we[gi] = bus_we && (bus_addr == ADDR_W'(tmr_rld_addr(gi)));
      ostt_downcount #(.W(CNT_W)) u_dc (
         .clk       (clk),
         .rst_n     (rst_n),
         .rld_we    (rld_we[gi]),
         .rld_wdata (bus_wdata),
         .rld       (rld[gi]),
         .cnt       (cnt[gi]),
         .load_pend (load_pend[gi]),
         .expire    (expire[gi])
      );
      assign irq_tmr[gi] = pend[gi];
   end

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < NUM_TMR; i++) set_vec[i] = expire[i];
      set_vec[ST_STAMP] = stamp_wrap;
   end

   ostt_status #(.N_SRC(ST_SRC), .MW(ST_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_vec),
      .clr_we   (st_we),
      .clr_mask (bus_wdata[ST_W-1:0]),
      .pend     (pend)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_STAMP))  bus_rdata = stamp_q;
      if (bus_addr == ADDR_W'(A_STATUS)) bus_rdata = CNT_W'(pend);
      for (int i = 0; i < NUM_TMR; i++) begin
         if (bus_addr == ADDR_W'(tmr_cnt_addr(i))) bus_rdata = cnt[i];
         if (bus_addr == ADDR_W'(tmr_rld_addr(i))) bus_rdata = rld[i];
      end
   end
endmodule

// File: rtl/ostt_checker.sv
module ostt_checker
   import ostt_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_TMR = 2,
   parameter int CNT_W   = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic                          bus_we,
   input logic [CNT_W-1:0]              bus_wdata,
   input logic [CNT_W-1:0]              stamp,
   input logic [NUM_TMR-1:0][CNT_W-1:0] rld,
   input logic [NUM_TMR-1:0][CNT_W-1:0] cnt,
   input logic [NUM_TMR-1:0]            load_pend,
   input logic [ST_SRC-1:0]             pend,
   input logic [NUM_TMR-1:0]            irq_tmr
);
   logic stamp_wr, st_wr;
   assign stamp_wr = bus_we && (bus_addr == ADDR_W'(A_STAMP));
   assign st_wr    = bus_we && (bus_addr == ADDR_W'(A_STATUS));

   p_stamp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stamp_wr |=> stamp == $past(stamp) + 1'b1);
   p_stamp_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_wr |=> stamp == $past(bus_wdata));
   p_wrap_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stamp_wr && stamp == {CNT_W{1'b1}}) |=> pend[ST_STAMP]);

   for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_chk
      logic rld_wr;
      assign rld_wr = bus_we && (bus_addr == ADDR_W'(tmr_rld_addr(gi)));

      p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
         load_pend[gi] |=> cnt[gi] == {$past(rld[gi][CNT_W-1:CTRL_W]), {CTRL_W{1'b0}}});
      p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!load_pend[gi] && rld[gi][EN_BIT] && cnt[gi] != '0) |=> cnt[gi] == $past(cnt[gi]) - 1'b1);
      p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!load_pend[gi] && rld[gi][EN_BIT] && rld[gi][ONESHOT_BIT] && cnt[gi] == '0 && !rld_wr)
         |=> (!rld[gi][EN_BIT] && cnt[gi] == '0));
      p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[gi] && !(st_wr && bus_wdata[gi])) |=> pend[gi]);
      p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_tmr[gi]) |-> $past(!load_pend[gi] && rld[gi][EN_BIT] && cnt[gi] == '0));
   end
endmodule

bind os_tick_timer ostt_checker #(
   .ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .stamp     (stamp_q),
   .rld       (rld),
   .cnt       (cnt),
   .load_pend (load_pend),
   .pend      (pend),
   .irq_tmr   (irq_tmr)
);

// File: tb/os_tick_timer_tb.sv
`timescale 1ns/1ps
module os_tick_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq_tmr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   os_tick_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_tmr(irq_tmr)
   );

   // cycle model built from the requirements
   logic [31:0] m_stamp;
   logic [31:0] m_cnt [2];
   logic [31:0] m_rld [2];
   bit          m_ld  [2];
   logic [2:0]  m_pend;

   function automatic logic [31:0] mread(input logic [7:0] a);
      case (a)
         8'h00: return m_stamp;
         8'h04: return m_cnt[0];
         8'h08: return m_rld[0];
         8'h0C: return m_cnt[1];
         8'h10: return m_rld[1];
         8'h20: return {29'd0, m_pend};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string req_of(input logic [7:0] a);
      case (a)
         8'h00: return "R2";
         8'h04, 8'h0C: return "R5";
         8'h08, 8'h10: return "R4";
         8'h20: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic mstep(input bit we, input logic [7:0] a, input logic [31:0] d);
      logic [2:0] set_v = '0;
      logic [2:0] clr_v = '0;
      if (we && a == 8'h00) m_stamp = d;
      else begin
         if (m_stamp == 32'hFFFF_FFFF) set_v[2] = 1'b1;  // R3
         m_stamp = m_stamp + 1;
      end
      for (int t = 0; t < 2; t++) begin
         logic [31:0] base = m_rld[t] & 32'hFFFF_FFFC;
         if (m_ld[t]) m_cnt[t] = base;
         else if (m_rld[t][0]) begin
            if (m_cnt[t] != 0) m_cnt[t] = m_cnt[t] - 1;
            else begin
               set_v[t] = 1'b1;
               if (m_rld[t][1]) m_rld[t][0] = 1'b0;
               else m_cnt[t] = base;
            end
         end
         m_ld[t] = 0;
         if (we && a == 8'(8 + 8 * t)) begin
            m_rld[t] = d;
            m_ld[t]  = d[0];
         end
      end
      if (we && a == 8'h20) clr_v = d[2:0];
      m_pend = (m_pend & ~clr_v) | set_v;
   endtask

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one bus cycle, starting and ending just after a falling edge
   task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d, input string tag = "");
      bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      check(bus_rdata, mread(a), (tag != "") ? tag : req_of(a), $sformatf("read @%h", a));
      check({30'd0, irq_tmr}, {30'd0, m_pend[1:0]}, "R9", "irq lines");
      @(posedge clk);
      mstep(we, a, d);
      @(negedge clk);
   endtask

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd20240611);
      m_stamp = '0; m_pend = '0;
      for (int t = 0; t < 2; t++) begin m_cnt[t] = '0; m_rld[t] = '0; m_ld[t] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cyc(0, 8'h04, 0, "R1"); cyc(0, 8'h08, 0, "R1"); cyc(0, 8'h0C, 0, "R1");
      cyc(0, 8'h10, 0, "R1"); cyc(0, 8'h20, 0, "R1"); cyc(0, 8'h00, 0, "R1");

      // R10: ignored writes and holes
      cyc(1, 8'h14, 32'hFFFF_FFFF); cyc(1, 8'h18, 32'hFFFF_FFFF); cyc(1, 8'h1C, 32'h0000_482E);
      cyc(1, 8'h04, 32'h1234_5678); cyc(1, 8'h0C, 32'h0BAD_F00D); cyc(1, 8'h30, 32'hFFFF_FFFF);
      cyc(0, 8'h14, 0, "R10"); cyc(0, 8'h18, 0, "R10"); cyc(0, 8'h1C, 0, "R10");
      cyc(0, 8'h04, 0, "R10"); cyc(0, 8'h0C, 0, "R10"); cyc(0, 8'h30, 0, "R10");

      // R4/R6: timer 0 periodic, period 8
      cyc(1, 8'h08, 32'h0000_0009);
      for (int k = 0; k < 30; k++) cyc(0, (k % 2) ? 8'h20 : 8'h04, 0, (k % 2) ? "R6" : "R5");
      cyc(1, 8'h20, 32'h1);
      cyc(0, 8'h20, 0, "R8");

      // R7: timer 1 one-shot, low bits of written period dropped
      cyc(1, 8'h10, 32'h0000_0007);
      for (int k = 0; k < 14; k++) cyc(0, (k % 2) ? 8'h10 : 8'h0C, 0, "R7");

      // R4: new period, controls kept
      cyc(1, 8'h08, 32'h0000_0041);
      cyc(0, 8'h08, 0, "R4"); cyc(0, 8'h04, 0, "R4");

      // R5: disable holds count
      cyc(1, 8'h08, 32'h0000_0040);
      for (int k = 0; k < 4; k++) cyc(0, 8'h04, 0, "R5");

      // R8: zeros keep bits, ones clear only their bit
      cyc(1, 8'h20, 32'h0);
      cyc(0, 8'h20, 0, "R8");
      cyc(1, 8'h20, 32'h2);
      cyc(0, 8'h20, 0, "R8");

      // R2/R3: wrap of the timestamp
      cyc(1, 8'h00, 32'hFFFF_FFFC);
      for (int k = 0; k < 6; k++) cyc(0, 8'h00, 0, "R2");
      cyc(0, 8'h20, 0, "R3");
      cyc(1, 8'h20, 32'h1F);
      cyc(0, 8'h20, 0, "R8");

      // constrained random traffic
      for (int k = 0; k < 4000; k++) begin
         int unsigned op = $urandom % 16;
         logic [31:0] d = (($urandom % 24) << 2) | ($urandom % 4);
         case (op)
            0: cyc(1, 8'h08, d);
            1: cyc(1, 8'h10, d);
            2: cyc(1, 8'h20, $urandom % 32);
            3: cyc(1, 8'h00, 32'hFFFF_FFFF - ($urandom % 12));
            4: cyc(1, ($urandom % 2) ? 8'h04 : 8'h0C, $urandom);
            5: cyc(1, 8'h14 + 8'(4 * ($urandom % 3)), $urandom);
            default: begin
               logic [7:0] a = 8'(4 * ($urandom % 10));
               cyc(0, a, 0);
            end
         endcase
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL R1 watchdog: actual=hung expected=finished within 150000 cycles");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule